// File: doc/BRIEF.md
# Dual-Output Cascaded Interrupt Router

This block gathers a wide bank of interrupt request lines (224 by default) and presents them to a parent controller as two level-sensitive interrupt outputs. For each source, software picks edge or level detection, the active sense, which of the two outputs it drives, and whether it is enabled. Edge events are held in per-source latches until software clears them by writing ones.

The register port has two regions, chosen by a select bit. The configuration region holds four per-source arrays of seven 32-bit words. The status region holds a write-one-to-clear array, masked pending status split by output, and one summary word. The summary word shows which 32-bit groups hold pending work for each output. A handler therefore finds its source in two reads: one for the summary and one for the flagged group word. Inputs are asynchronous and pass through a two-flop synchroniser. Reads return data one cycle after the read strobe.

Top module: `dual_irq_router`

## Requirements
- R1: After reset every source is edge triggered, active-high, routed to output 0 and masked, and all edge latches are clear. Config words read trig=all ones, sense=0, route=all ones, enable=0. Both outputs are low and all status words read 0.
- R2: Configuration region (bus_sel=0) word map: words 0-6 trigger type (1=edge, 0=level), 7-13 sense, 14-20 route, 21-27 enable. Word k of an array holds sources 32k..32k+31, with bit b being source 32k+b. A write stores the data. A read returns it on bus_rdata one cycle after bus_rd, and bus_rdata holds between reads.
- R3: An edge-triggered source latches pending on a rising edge of its synchronised input when sense=0, and on a falling edge when sense=1. The latch holds after the input returns, until a 1 is written to its bit in status words 0-6 (bus_sel=1). The latch is set by the third clock edge after the input changes.
- R4: If a clear write and a new selected edge reach the same latch in the same cycle, the latch stays set.
- R5: A level-triggered source is pending while its synchronised input XOR its sense bit is 1, which is two clock edges after the input changes. Clear writes do not affect it.
- R6: A source whose enable bit is 0 contributes to no output and no status word.
- R7: Route bit 1 sends a source to irq_out0 and 0 sends it to irq_out1. Status words 7-13 show masked pending sources routed to output 1, and words 14-20 show those routed to output 0.
- R8: Status word 31 has bit g (g=0..6) set when group g has any masked pending source for output 1, and bit 8+g set for output 0. All other bits read 0.
- R9: Writes to status words 7-20 and 31 are ignored. Status words 0-6 read as 0. Writes to the status region leave the configuration unchanged.
- R10: Each output is the OR of all enabled pending sources routed to it, and stays high as long as any such source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 224 | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Region select: 0 configuration, 1 status |
| bus_addr | input | 5 | Word index within the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq_out0 | output | 1 | Parent interrupt output 0 (level) |
| irq_out1 | output | 1 | Parent interrupt output 1 (level) |

## Verification
Directed sequences on single sources test the edge and level paths separately. A rising input under sense=1 must not latch, and a falling input must, which shows that edge selection follows the sense bit. A level source that stays high across a clear write shows the clear acts only on latches. A clear timed to land in the same cycle as a new edge checks the set-wins rule. Random configurations then mix edge and level sources, both senses, both routes and sparse enables under randomly toggling inputs. After each step the bench compares both status arrays, the summary word and both outputs against a reference model. This catches wrong group placement, swapped output ordering and leaks from masked sources.

// File: rtl/dual_irq_router.sv
module dual_irq_router #(
  parameter int N_SRC = 224,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_sel,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_out0,
  output logic             irq_out1
);
  localparam int NG       = (N_SRC + DW - 1) / DW;
  localparam int NB       = NG * DW;
  localparam int SUM_ADDR = (1 << AW) - 1;
  localparam int HI_POS   = 8;

  logic [NB-1:0] trig, sense, route, en, lat;
  logic [NB-1:0] in_pad, s1, s2, s3;
  logic [NB-1:0] clr_vec, hit, pend, mp0, mp1;
  logic [NG-1:0] grp0, grp1;
  logic [DW-1:0] sum_word, rd_val;

  always_comb begin
    in_pad = '0;
    in_pad[N_SRC-1:0] = irq_in;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= in_pad; s2 <= s1; s3 <= s2;
    end

  assign hit  = trig & ((~sense & s2 & ~s3) | (sense & ~s2 & s3));
  assign pend = (trig & lat) | (~trig & (s2 ^ sense));
  assign mp0  = pend & en & route;
  assign mp1  = pend & en & ~route;

  always_comb begin
    clr_vec = '0;
    for (int g = 0; g < NG; g++)
      if (bus_wr && bus_sel && int'(bus_addr) == g) clr_vec[g*DW +: DW] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~clr_vec) | hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig  <= '1;
      sense <= '0;
      route <= '1;
      en    <= '0;
    end else if (bus_wr && !bus_sel) begin
      for (int g = 0; g < NG; g++) begin
        if (int'(bus_addr) == g)        trig[g*DW +: DW]  <= bus_wdata;
        if (int'(bus_addr) == NG + g)   sense[g*DW +: DW] <= bus_wdata;
        if (int'(bus_addr) == 2*NG + g) route[g*DW +: DW] <= bus_wdata;
        if (int'(bus_addr) == 3*NG + g) en[g*DW +: DW]    <= bus_wdata;
      end
    end

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      grp0[g] = |mp0[g*DW +: DW];
      grp1[g] = |mp1[g*DW +: DW];
    end
    sum_word = '0;
    sum_word[NG-1:0] = grp1;
    sum_word[HI_POS +: NG] = grp0;
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NG; g++) begin
      if (!bus_sel) begin
        if (int'(bus_addr) == g)        rd_val = trig[g*DW +: DW];
        if (int'(bus_addr) == NG + g)   rd_val = sense[g*DW +: DW];
        if (int'(bus_addr) == 2*NG + g) rd_val = route[g*DW +: DW];
        if (int'(bus_addr) == 3*NG + g) rd_val = en[g*DW +: DW];
      end else begin
        if (int'(bus_addr) == NG + g)   rd_val = mp1[g*DW +: DW];
        if (int'(bus_addr) == 2*NG + g) rd_val = mp0[g*DW +: DW];
      end
    end
    if (bus_sel && int'(bus_addr) == SUM_ADDR) rd_val = sum_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;

  assign irq_out0 = |mp0;
  assign irq_out1 = |mp1;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_out0 && !irq_out1)); // R6
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel) |=> ((lat & $past(lat)) == $past(lat))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_sel) |=> ($stable(trig) && $stable(sense) && $stable(route) && $stable(en))); // R9
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (((sum_word[HI_POS +: NG] != '0) == irq_out0) && ((sum_word[NG-1:0] != '0) == irq_out1))); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
endmodule

// File: tb/dual_irq_router_tb_top.sv
module dual_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 224;
  localparam int NG = 7;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic bus_wr = 0, bus_rd = 0, bus_sel = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out0, irq_out1;

  int checks = 0, errors = 0;
  logic [N-1:0] m_trig, m_sense, m_route, m_en, m_lat, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_router dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out0(irq_out0), .irq_out1(irq_out1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int a, input logic [31:0] d);
    bus_wr = 1; bus_sel = sel; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic sel, input int a, output logic [31:0] d);
    bus_rd = 1; bus_sel = sel; bus_addr = 5'(a);
    @(posedge clk); @(negedge clk);
    bus_rd = 0; d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N-1:0] m_pend();
    return ((m_trig & m_lat) | (~m_trig & (irq_in ^ m_sense))) & m_en;
  endfunction

  function automatic logic [31:0] m_sum();
    logic [N-1:0] p = m_pend();
    logic [31:0] s = '0;
    for (int g = 0; g < NG; g++) begin
      s[g]   = |(p[g*32 +: 32] & ~m_route[g*32 +: 32]);
      s[8+g] = |(p[g*32 +: 32] & m_route[g*32 +: 32]);
    end
    return s;
  endfunction

  function automatic logic [N-1:0] rvec();
    logic [N-1:0] v;
    for (int g = 0; g < NG; g++) v[g*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic cfg_all(input logic [N-1:0] t, input logic [N-1:0] s,
                         input logic [N-1:0] r, input logic [N-1:0] e);
    for (int g = 0; g < NG; g++) begin
      wr(0, g, t[g*32 +: 32]);      wr(0, NG+g, s[g*32 +: 32]);
      wr(0, 2*NG+g, r[g*32 +: 32]); wr(0, 3*NG+g, e[g*32 +: 32]);
    end
    m_trig = t; m_sense = s; m_route = r; m_en = e;
  endtask

  task automatic compare_all();
    logic [31:0] d;
    logic [N-1:0] p = m_pend();
    chk("R10 irq_out0", {31'd0, irq_out0}, {31'd0, |(p & m_route)});
    chk("R10 irq_out1", {31'd0, irq_out1}, {31'd0, |(p & ~m_route)});
    for (int g = 0; g < NG; g++) begin
      rd(1, NG+g, d);   chk("R7 out1 status", d, p[g*32 +: 32] & ~m_route[g*32 +: 32]);
      rd(1, 2*NG+g, d); chk("R7 out0 status", d, p[g*32 +: 32] & m_route[g*32 +: 32]);
    end
    rd(1, 31, d); chk("R8 summary", d, m_sum());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20211207));
    waitn(3); rst_n = 1; waitn(1);

    chk("R1 out0", {31'd0, irq_out0}, 0);
    chk("R1 out1", {31'd0, irq_out1}, 0);
    for (int g = 0; g < NG; g++) begin
      rd(0, g, d);        chk("R1 R2 trig", d, '1);
      rd(0, NG+g, d);     chk("R1 R2 sense", d, '0);
      rd(0, 2*NG+g, d);   chk("R1 R2 route", d, '1);
      rd(0, 3*NG+g, d);   chk("R1 R2 enable", d, '0);
    end
    rd(1, 31, d); chk("R1 summary", d, 0);

    // R3 rising edge on source 5, routed to out0
    wr(0, 3*NG, 32'h20);
    irq_in[5] = 1; waitn(4);
    chk("R3 rising latch", {31'd0, irq_out0}, 1);
    irq_in[5] = 0; waitn(4);
    chk("R3 latch holds", {31'd0, irq_out0}, 1);
    wr(1, 0, 32'h20); waitn(1);
    chk("R3 cleared", {31'd0, irq_out0}, 0);
    wr(0, NG, 32'h20);
    irq_in[5] = 1; waitn(4);
    chk("R3 sense1 ignores rise", {31'd0, irq_out0}, 0);
    irq_in[5] = 0; waitn(4);
    chk("R3 sense1 falling latch", {31'd0, irq_out0}, 1);
    wr(1, 0, 32'h20); wr(0, NG, 32'h0); waitn(1);
    chk("R3 cleared again", {31'd0, irq_out0}, 0);

    // R4 clear collides with new edge
    irq_in[5] = 1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    wr(1, 0, 32'h20); waitn(1);
    chk("R4 set wins over clear", {31'd0, irq_out0}, 1);
    wr(1, 0, 32'h20); waitn(1);
    chk("R4 later clear works", {31'd0, irq_out0}, 0);
    irq_in[5] = 0; wr(0, 3*NG, 0); waitn(4);

    // R5 level source 40 routed to out1
    wr(0, 1, ~32'h100); wr(0, 2*NG+1, ~32'h100); wr(0, 3*NG+1, 32'h100);
    irq_in[40] = 1; waitn(3);
    chk("R5 level active", {31'd0, irq_out1}, 1);
    chk("R7 not on out0", {31'd0, irq_out0}, 0);
    rd(1, NG+1, d); chk("R7 out1 word", d, 32'h100);
    rd(1, 2*NG+1, d); chk("R7 out0 word", d, 0);
    rd(1, 31, d); chk("R8 summary group1 out1", d, 32'h2);
    wr(1, 1, 32'h100); waitn(1);
    chk("R5 clear no effect", {31'd0, irq_out1}, 1);
    // R9 status writes ignored
    wr(1, NG+1, 32'h0); wr(1, 31, 32'h0); wr(1, 2*NG+1, '1);
    rd(1, NG+1, d); chk("R9 status write ignored", d, 32'h100);
    rd(1, 31, d); chk("R9 summary write ignored", d, 32'h2);
    rd(1, 1, d); chk("R9 clear word reads 0", d, 0);
    rd(0, 3*NG+1, d); chk("R9 cfg untouched", d, 32'h100);
    irq_in[40] = 0; waitn(3);
    chk("R5 level inactive", {31'd0, irq_out1}, 0);
    wr(0, NG+1, 32'h100); waitn(1);
    chk("R5 active-low", {31'd0, irq_out1}, 1);
    wr(0, 3*NG+1, 0);
    chk("R6 masked", {31'd0, irq_out1}, 0);

    // random phase
    m_prev = irq_in; m_lat = '0;
    for (int it = 0; it < 30; it++) begin
      cfg_all(rvec(), rvec(), rvec(), rvec() & rvec() | ((it % 3 == 0) ? rvec() : '0));
      for (int g = 0; g < NG; g++) wr(1, g, '1);
      m_lat = '0;
      for (int st = 0; st < 4; st++) begin
        irq_in = irq_in ^ (rvec() & rvec() & rvec());
        m_lat = m_lat | (m_trig & ((~m_sense & irq_in & ~m_prev) | (m_sense & ~irq_in & m_prev)));
        m_prev = irq_in;
        waitn(4);
        compare_all();
        if (st == 2) begin
          logic [31:0] c = $urandom;
          wr(1, st, c);
          m_lat[st*32 +: 32] = m_lat[st*32 +: 32] & ~c;
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule